// File: doc/BRIEF.md
# Daisy-Chained Bus Grant Arbiter

This block decides which master drives a shared system bus. A processor holds the bus by default. A row of DMA controller slots hangs off one bus-request line, which is the OR of every slot's pending request. When the processor sees that line high it leaves the bus and raises a single grant. The grant enters the slot nearest the processor and is passed from slot to slot within the same cycle. The first slot that holds a pending request keeps it.

The slot that catches the grant withdraws its request. It then waits until the shared busy line is low and raises busy itself, which makes it the owner. Ownership is taken through the busy line, not through the grant. When a controller reports that its transfer is finished, it drops busy. The processor then takes the bus back, or grants it again at once if another request is waiting. Priority is fixed by position in the chain: slot 0 is closest to the processor and has the highest priority.

Top module: `bus_arb_chain`

## Requirements
- R1: After reset the processor owns the bus (`cpu_owner_o`=1, `bus_busy_o`=1), and `bus_req_o`, `bus_grant_o`, `grant_chain_o`, `grant_tail_o` and `owner_o` are all 0.
- R2: A slot that is idle and sees no incoming grant registers `dma_want_i[i]` as a pending request at a clock edge. From the next cycle `bus_req_o` is high. Whenever no grant is out, `bus_req_o` equals the OR of the pending requests.
- R3: While the processor owns the bus and `bus_req_o` is high, the next cycle raises `bus_grant_o` and clears `cpu_owner_o`. The processor never owns the bus while the grant is high.
- R4: `grant_chain_o[i]` is the grant seen at the input of slot i. An idle slot passes it on in the same cycle. A slot that is pending, waiting or owning stops it. `grant_tail_o`, the grant leaving the last slot, is never high.
- R5: When the grant rises, the pending slot with the lowest index becomes the next owner.
- R6: A slot that holds a request and sees the grant drops its request in the next cycle. It raises `owner_o[i]` only after a cycle in which `bus_busy_o` was low. While it owns the bus it keeps `bus_busy_o` high.
- R7: The cycle after a slot first owns the bus while the grant is high, `bus_grant_o` falls.
- R8: A `dma_done_i[i]` pulse from the owner clears `owner_o[i]` and `bus_busy_o` in the next cycle. One cycle later the processor either owns the bus again, if no request is pending, or raises a new grant without owning the bus in between.
- R9: At most one of `cpu_owner_o` and the bits of `owner_o` is high in any cycle.
- R10: `dma_done_i[i]` to a slot that does not own the bus has no effect. `dma_want_i[i]` to a slot that is already pending or owning has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dma_want_i | input | N_SLOTS | Per-slot request to use the bus |
| dma_done_i | input | N_SLOTS | Per-slot end-of-transfer pulse |
| bus_req_o | output | 1 | Shared request line (OR of pending slots) |
| bus_grant_o | output | 1 | Grant driven by the processor into the chain |
| grant_chain_o | output | N_SLOTS | Grant arriving at each slot |
| grant_tail_o | output | 1 | Grant passed beyond the last slot |
| owner_o | output | N_SLOTS | One-hot slot that owns the bus |
| cpu_owner_o | output | 1 | Processor owns the bus |
| bus_busy_o | output | 1 | Shared busy line |

## Verification
Two kinds of event can fall on the same clock edge.

The first pair is a new request and the processor raising the grant. A slot nearer the processor that registers its request on that edge must still catch the grant ahead of a lower slot that asked earlier. Random stimulus issues requests on every cycle in which no grant is out, so it often hits this edge. The bench records the lowest pending slot at the moment the grant rises and compares it with the slot that later becomes owner.

The second pair is an owner's done pulse and a pending request. Here the processor must issue a fresh grant without owning the bus in between. A directed case with two requesting slots checks `cpu_owner_o` at that cycle.

// File: rtl/bus_arb_pkg.sv
package bus_arb_pkg;
  typedef enum logic [1:0] {
    SLOT_IDLE,
    SLOT_PEND,
    SLOT_WAIT,
    SLOT_OWN
  } slot_state_e;

  typedef enum logic [1:0] {
    CPU_HOLD,
    CPU_GRANT,
    CPU_YIELD
  } cpu_state_e;
endpackage

// File: rtl/bus_arb_cpu.sv
module bus_arb_cpu
  import bus_arb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic busy_i,
  output logic grant_o,
  output logic own_o
);
  cpu_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      CPU_HOLD:  if (req_i) state_d = CPU_GRANT;
      CPU_GRANT: if (busy_i) state_d = CPU_YIELD;  // a slot has raised busy
      CPU_YIELD: if (!busy_i) state_d = req_i ? CPU_GRANT : CPU_HOLD;
      default:   state_d = CPU_HOLD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= CPU_HOLD;
    else         state_q <= state_d;
  end

  assign grant_o = (state_q == CPU_GRANT);
  assign own_o   = (state_q == CPU_HOLD);
endmodule

// File: rtl/bus_arb_slot.sv
module bus_arb_slot
  import bus_arb_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic want_i,
  input  logic done_i,
  input  logic grant_in_i,
  input  logic busy_i,
  output logic grant_out_o,
  output logic req_o,
  output logic own_o
);
  slot_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      // new requests only join while the chain is quiet at this slot
      SLOT_IDLE: if (want_i && !grant_in_i) state_d = SLOT_PEND;
      SLOT_PEND: if (grant_in_i) state_d = SLOT_WAIT;
      SLOT_WAIT: if (!busy_i) state_d = SLOT_OWN;
      SLOT_OWN:  if (done_i) state_d = SLOT_IDLE;
      default:   state_d = SLOT_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SLOT_IDLE;
    else         state_q <= state_d;
  end

  assign grant_out_o = grant_in_i && (state_q == SLOT_IDLE);
  assign req_o       = (state_q == SLOT_PEND);
  assign own_o       = (state_q == SLOT_OWN);
endmodule

// File: rtl/bus_arb_chain.sv
module bus_arb_chain #(
  parameter int N_SLOTS = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_SLOTS-1:0] dma_want_i,
  input  logic [N_SLOTS-1:0] dma_done_i,
  output logic               bus_req_o,
  output logic               bus_grant_o,
  output logic [N_SLOTS-1:0] grant_chain_o,
  output logic               grant_tail_o,
  output logic [N_SLOTS-1:0] owner_o,
  output logic               cpu_owner_o,
  output logic               bus_busy_o
);
  localparam int LAST = N_SLOTS - 1;

  logic [N_SLOTS-1:0] slot_req;
  logic [N_SLOTS-1:0] slot_own;
  logic [N_SLOTS-1:0] chain_in;
  logic [N_SLOTS-1:0] chain_out;
  logic               cpu_grant;
  logic               cpu_own;

  bus_arb_cpu u_cpu (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (bus_req_o),
    .busy_i (bus_busy_o),
    .grant_o(cpu_grant),
    .own_o  (cpu_own)
  );

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
    if (i == 0) begin : g_head
      assign chain_in[i] = cpu_grant;
    end else begin : g_link
      assign chain_in[i] = chain_out[i-1];
    end

    bus_arb_slot u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .want_i     (dma_want_i[i]),
      .done_i     (dma_done_i[i]),
      .grant_in_i (chain_in[i]),
      .busy_i     (bus_busy_o),
      .grant_out_o(chain_out[i]),
      .req_o      (slot_req[i]),
      .own_o      (slot_own[i])
    );
  end

  assign bus_req_o     = |slot_req;
  assign bus_busy_o    = cpu_own | (|slot_own);
  assign bus_grant_o   = cpu_grant;
  assign grant_chain_o = chain_in;
  assign grant_tail_o  = chain_out[LAST];
  assign owner_o       = slot_own;
  assign cpu_owner_o   = cpu_own;
endmodule

// File: rtl/bus_arb_chain_chk.sv
module bus_arb_chain_chk #(
  parameter int N_SLOTS = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_SLOTS-1:0] slot_req,
  input logic [N_SLOTS-1:0] grant_chain,
  input logic               grant_tail,
  input logic [N_SLOTS-1:0] owner,
  input logic               cpu_owner,
  input logic               bus_grant,
  input logic               bus_busy
);
  AST_ONE_MASTER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cpu_owner, owner})); // R9

  AST_NO_FALLTHROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !grant_tail); // R4

  AST_CPU_OFF_WHEN_GRANTING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_grant |-> !cpu_owner); // R3

  AST_GRANT_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_grant && (|owner)) |=> !bus_grant); // R7

  AST_OWNER_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|owner) |-> bus_busy); // R6

  for (genvar i = 0; i < N_SLOTS; i++) begin : g_chk
    AST_REQ_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant_chain[i] && slot_req[i]) |=> !slot_req[i]); // R6

    AST_OWN_AFTER_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(owner[i]) |-> $past(!bus_busy)); // R6

    if (i < N_SLOTS - 1) begin : g_stop
      AST_CHAIN_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (grant_chain[i] && slot_req[i]) |-> !grant_chain[i+1]); // R5
    end
  end
endmodule

bind bus_arb_chain bus_arb_chain_chk #(.N_SLOTS(N_SLOTS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .slot_req   (slot_req),
  .grant_chain(grant_chain_o),
  .grant_tail (grant_tail_o),
  .owner      (owner_o),
  .cpu_owner  (cpu_owner_o),
  .bus_grant  (bus_grant_o),
  .bus_busy   (bus_busy_o)
);

// File: tb/bus_arb_chain_bench.sv
module bus_arb_chain_bench;
  localparam int N = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] dma_want_i = '0;
  logic [N-1:0] dma_done_i = '0;
  logic         bus_req_o, bus_grant_o, grant_tail_o, cpu_owner_o, bus_busy_o;
  logic [N-1:0] grant_chain_o, owner_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;

  bus_arb_chain #(.N_SLOTS(N)) u_bus_arb_chain (
    .clk_i(clk_i), .rst_ni(rst_ni), .dma_want_i(dma_want_i), .dma_done_i(dma_done_i),
    .bus_req_o(bus_req_o), .bus_grant_o(bus_grant_o), .grant_chain_o(grant_chain_o),
    .grant_tail_o(grant_tail_o), .owner_o(owner_o), .cpu_owner_o(cpu_owner_o),
    .bus_busy_o(bus_busy_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  function automatic int lowest(input logic [N-1:0] m);
    for (int i = 0; i < N; i++) if (m[i]) return i;
    return -1;
  endfunction

  task automatic step();
    @(negedge clk_i);
  endtask

  initial begin
    logic [N-1:0] pending;
    logic [N-1:0] last_want, last_owner, prev_owner;
    bit prev_grant;
    int winner, hold;
    void'($urandom(32'd20240611));

    // reset state
    step();
    eq("R1 cpu_owner", cpu_owner_o, 1);
    eq("R1 busy", bus_busy_o, 1);
    eq("R1 req/grant/tail", {bus_req_o, bus_grant_o, grant_tail_o}, 0);
    eq("R1 owner/chain", {owner_o, grant_chain_o}, 0);
    rst_ni = 1'b1;
    step();

    // single request on slot 2
    dma_want_i = 4'b0100;
    step();
    dma_want_i = '0;
    eq("R2 bus_req raised", bus_req_o, 1);
    eq("R2 cpu still owner", cpu_owner_o, 1);
    step();
    eq("R3 grant raised", bus_grant_o, 1);
    eq("R3 cpu released", cpu_owner_o, 0);
    eq("R4 chain stops at slot 2", grant_chain_o, 4'b0111);
    step();
    eq("R6 request dropped", bus_req_o, 0);
    eq("R6 not yet owner", owner_o, 0);
    step();
    eq("R6 slot 2 owns", owner_o, 4'b0100);
    eq("R6 busy from slot", bus_busy_o, 1);
    step();
    eq("R7 grant dropped", bus_grant_o, 0);
    dma_done_i = 4'b0001;
    dma_want_i = 4'b0100;
    step();
    dma_done_i = '0;
    dma_want_i = '0;
    eq("R10 stray done ignored", owner_o, 4'b0100);
    eq("R10 want to owner ignored", bus_req_o, 0);
    dma_done_i = 4'b0100;
    step();
    dma_done_i = '0;
    eq("R8 owner cleared", owner_o, 0);
    eq("R8 busy cleared", bus_busy_o, 0);
    step();
    eq("R8 cpu resumes", cpu_owner_o, 1);
    eq("R8 no new grant", bus_grant_o, 0);

    // slots 1 and 3 together
    dma_want_i = 4'b1010;
    step();
    dma_want_i = '0;
    step();
    eq("R4 chain stops at slot 1", grant_chain_o, 4'b0011);
    step();
    step();
    eq("R5 slot 1 wins", owner_o, 4'b0010);
    step();
    eq("R7 grant dropped", bus_grant_o, 0);
    eq("R2 slot 3 still pending", bus_req_o, 1);
    dma_done_i = 4'b0010;
    step();
    dma_done_i = '0;
    eq("R8 busy cleared", bus_busy_o, 0);
    step();
    eq("R8 regrant", bus_grant_o, 1);
    eq("R8 cpu skips ownership", cpu_owner_o, 0);
    step();
    step();
    eq("R5 slot 3 owns", owner_o, 4'b1000);
    step();
    dma_done_i = 4'b1000;
    step();
    dma_done_i = '0;
    step();
    eq("R8 cpu resumes", cpu_owner_o, 1);

    // random phase
    pending = '0; last_want = '0; last_owner = '0; prev_owner = '0;
    prev_grant = 1'b0; winner = -1; hold = 0;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      pending |= last_want & ~pending & ~last_owner;
      if (bus_grant_o && !prev_grant) begin
        winner = lowest(pending);
        check(pending != 0, "R5 grant with pending", pending, 1);
      end
      if (owner_o != 0 && prev_owner == 0) begin
        eq("R5 lowest pending owns", owner_o, (winner >= 0) ? (1 << winner) : 0);
        pending &= ~owner_o;
        hold = 1 + int'($urandom % 5);
      end
      check($countones({cpu_owner_o, owner_o}) <= 1, "R9 single master",
            {cpu_owner_o, owner_o}, 0);
      eq("R4 tail", grant_tail_o, 0);
      if (!bus_grant_o) eq("R2 req is OR of pending", bus_req_o, (pending != 0));
      prev_grant = bus_grant_o;
      prev_owner = owner_o;
      // drive
      dma_want_i = (!bus_grant_o && ($urandom % 3 == 0)) ? N'($urandom) : '0;
      last_want  = dma_want_i;
      last_owner = owner_o;
      if (owner_o != 0) begin
        if (hold > 0) begin
          hold--;
          dma_done_i = N'($urandom) & ~owner_o;  // R10 stray pulses
        end else begin
          dma_done_i = owner_o;
        end
      end else begin
        dma_done_i = N'($urandom);
      end
      step();
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule